// File: doc/BRIEF.md
# Saturating PI Loop Filter

This block is the loop filter of a digital clock-recovery loop. It receives a signed phase-error word from a phase detector and turns it into a signed control word for the numerically controlled oscillator that follows. The filter has two paths. The proportional path shifts the error left by a programmable gain. The integral path shifts the error by a second gain and adds it to a running sum. The control word is the sum of the proportional term and the updated running sum.

Each stage clamps its result to the signed range of the control word, and a registered flag reports each clamp. The scaled inputs share one flag, and the integrator and the output have one flag each. Two controls act on the output register only. Hold keeps the current control word. Offset override loads a supplied word in place of the filtered value. The integrator keeps running in both cases.

The error enters through a valid/ready handshake. Ready equals the filter's clock enable, `step_ce`, and does not depend on valid. A source that raises `err_valid` must hold `err_data` steady until it sees `err_ready` high at a clock edge. A word is consumed only on an edge where both are high. The gains, hold, override and offset are plain levels, sampled on that same edge.

Top module: `pi_loop_filter`

## Requirements
- R1: A synchronous active-high reset clears the control word, the integrator and all three saturation flags to zero.
- R2: `err_ready` equals `step_ce`. A transfer happens only on an edge where `err_valid` and `step_ce` are both high. On every other edge the control word, the flags and the integrator keep their values.
- R3: The proportional term is the sign-extended error shifted left by the proportional gain, clamped to the signed OUT_W range. A gain above LIN_GMAX (default 18) acts as LIN_GMAX.
- R4: On each transfer, the integral term is the error shifted left by the integral gain (a gain above INT_GMAX, default 20, acts as INT_GMAX), clamped to the signed OUT_W range, and added to the integrator. When that sum leaves the range, the integrator keeps the clamped rail value and resumes from there.
- R5: With hold and override low, a transfer loads the control word with the clamped sum of the proportional term and the updated integrator.
- R6: `in_sat` is registered on each transfer and is high when either scaled term was clamped.
- R7: `int_sat` is registered on each transfer and is high when the integrator sum was clamped. While it is high, the integrator sits at one of its rails.
- R8: `out_sat` is registered on each transfer and is high when the proportional-plus-integral sum was clamped. This holds whether or not hold or override are active.
- R9: When `hold` is high on a transfer, the control word keeps its value. The integrator and the flags still update.
- R10: When `offset_en` is high and `hold` is low on a transfer, the control word loads `offset_val`.
- R11: The three flags change only on transfer edges. Each keeps its value until the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_ce | input | 1 | Filter clock enable; paces transfers |
| err_valid | input | 1 | Phase-error word is valid |
| err_ready | output | 1 | Filter can accept a word this edge |
| err_data | input | ERR_W (21) | Signed phase error |
| lin_gain | input | GAIN_W (5) | Proportional shift, 0 to LIN_GMAX |
| int_gain | input | GAIN_W (5) | Integral shift, 0 to INT_GMAX |
| hold | input | 1 | Freeze the control word |
| offset_en | input | 1 | Load offset_val in place of the filtered value |
| offset_val | input | OUT_W (22) | Signed override word |
| ctrl_out | output | OUT_W (22) | Signed control word |
| in_sat | output | 1 | A scaled input term was clamped |
| int_sat | output | 1 | Integrator sum was clamped |
| out_sat | output | 1 | Output sum was clamped |

## Verification
The bench uses a reduced configuration: a 4-bit error, a 6-bit output and gain limits of 3 and 4. In that configuration it sweeps every error value against every pair of gains from zero to one step past each limit. This shows whether gain clamping, proportional clamping and integral clamping are each correct on their own. Resets between gain rows start the integrator from zero, and the long runs within a row drive it onto both rails, which tests the clamped-rail behaviour. Separate passes cover hold, override and hold-plus-override. They also step through edges with only valid or only the enable high, which tests that neither alone causes a transfer.

// File: rtl/pi_filt_pkg.sv
package pi_filt_pkg;
  localparam int DEF_ERR_W    = 21;
  localparam int DEF_OUT_W    = 22;
  localparam int DEF_GAIN_W   = 5;
  localparam int DEF_LIN_GMAX = 18;
  localparam int DEF_INT_GMAX = 20;

  // index of each scaling path in the generated shifter array
  typedef enum logic {
    PATH_LIN = 1'b0,
    PATH_INT = 1'b1
  } path_e;

  typedef struct packed {
    logic in_sat;
    logic int_sat;
    logic out_sat;
  } sat_flags_t;
endpackage

// File: rtl/pi_gain_shift.sv
module pi_gain_shift #(
  parameter int ERR_W  = 21,
  parameter int OUT_W  = 22,
  parameter int GAIN_W = 5,
  parameter int MAX_G  = 18
) (
  input  logic [ERR_W-1:0]  err,
  input  logic [GAIN_W-1:0] gain,
  output logic [OUT_W-1:0]  term,
  output logic              clamped
);
  localparam int SH_W   = ERR_W + MAX_G;
  localparam int WIDE_W = ((SH_W > OUT_W) ? SH_W : OUT_W) + 1;
  localparam logic [GAIN_W-1:0] GMAX_V = GAIN_W'(MAX_G);
  localparam logic signed [WIDE_W-1:0] HI_V =
    {{(WIDE_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] LO_V =
    {{(WIDE_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic [GAIN_W-1:0]        g_eff;
  logic signed [WIDE_W-1:0] ext;
  logic signed [WIDE_W-1:0] shifted;
  logic                     over_hi;
  logic                     under_lo;

  // out-of-range gain settings saturate at the path limit
  assign g_eff    = (gain > GMAX_V) ? GMAX_V : gain;
  assign ext      = {{(WIDE_W-ERR_W){err[ERR_W-1]}}, err};
  assign shifted  = ext <<< g_eff;
  assign over_hi  = shifted > HI_V;
  assign under_lo = shifted < LO_V;
  assign clamped  = over_hi | under_lo;

  always_comb begin
    if (over_hi)       term = HI_V[OUT_W-1:0];
    else if (under_lo) term = LO_V[OUT_W-1:0];
    else               term = shifted[OUT_W-1:0];
  end
endmodule

// File: rtl/pi_sat_add.sv
module pi_sat_add #(
  parameter int W = 22
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         clamped
);
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  logic [W:0] raw;

  assign raw     = {a[W-1], a} + {b[W-1], b};
  assign clamped = raw[W] ^ raw[W-1];
  assign sum     = clamped ? (raw[W] ? MIN_V : MAX_V) : raw[W-1:0];
endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter
  import pi_filt_pkg::*;
#(
  parameter int ERR_W    = DEF_ERR_W,
  parameter int OUT_W    = DEF_OUT_W,
  parameter int GAIN_W   = DEF_GAIN_W,
  parameter int LIN_GMAX = DEF_LIN_GMAX,
  parameter int INT_GMAX = DEF_INT_GMAX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_ce,
  input  logic              err_valid,
  output logic              err_ready,
  input  logic [ERR_W-1:0]  err_data,
  input  logic [GAIN_W-1:0] lin_gain,
  input  logic [GAIN_W-1:0] int_gain,
  input  logic              hold,
  input  logic              offset_en,
  input  logic [OUT_W-1:0]  offset_val,
  output logic [OUT_W-1:0]  ctrl_out,
  output logic              in_sat,
  output logic              int_sat,
  output logic              out_sat
);
  localparam int NPATH = 2;
  localparam logic [OUT_W-1:0] RAIL_HI = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] RAIL_LO = {1'b1, {(OUT_W-1){1'b0}}};

  logic [GAIN_W-1:0] gain_a [NPATH];
  logic [OUT_W-1:0]  term_a [NPATH];
  logic [NPATH-1:0]  tclamp;
  logic [OUT_W-1:0]  integ_q;
  logic [OUT_W-1:0]  integ_nx;
  logic              integ_clamp;
  logic [OUT_W-1:0]  filt_val;
  logic              filt_clamp;
  sat_flags_t        flags_q;
  logic              fire;

  assign err_ready = step_ce;
  assign fire      = err_valid & step_ce;

  assign gain_a[PATH_LIN] = lin_gain;
  assign gain_a[PATH_INT] = int_gain;

  // one shifter per path; the path index picks its gain ceiling
  for (genvar p = 0; p < NPATH; p++) begin : g_path
    localparam int GM = (p == int'(PATH_LIN)) ? LIN_GMAX : INT_GMAX;
    pi_gain_shift #(
      .ERR_W (ERR_W),
      .OUT_W (OUT_W),
      .GAIN_W(GAIN_W),
      .MAX_G (GM)
    ) u_shift (
      .err    (err_data),
      .gain   (gain_a[p]),
      .term   (term_a[p]),
      .clamped(tclamp[p])
    );
  end

  pi_sat_add #(.W(OUT_W)) u_int_add (
    .a      (integ_q),
    .b      (term_a[PATH_INT]),
    .sum    (integ_nx),
    .clamped(integ_clamp)
  );

  pi_sat_add #(.W(OUT_W)) u_out_add (
    .a      (term_a[PATH_LIN]),
    .b      (integ_nx),
    .sum    (filt_val),
    .clamped(filt_clamp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q  <= '0;
      ctrl_out <= '0;
      flags_q  <= '0;
    end else if (fire) begin
      integ_q         <= integ_nx;
      flags_q.in_sat  <= |tclamp;
      flags_q.int_sat <= integ_clamp;
      flags_q.out_sat <= filt_clamp;
      if (!hold) ctrl_out <= offset_en ? offset_val : filt_val;
    end
  end

  assign in_sat  = flags_q.in_sat;
  assign int_sat = flags_q.int_sat;
  assign out_sat = flags_q.out_sat;

  AST_IDLE_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(ctrl_out) && $stable(integ_q)); // R2
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(ctrl_out)); // R9
  AST_OFFSET_LOADS: assert property (@(posedge clk) disable iff (rst)
    fire && offset_en && !hold |=> ctrl_out == $past(offset_val)); // R10
  AST_FLAGS_STABLE: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(flags_q)); // R11
  AST_INT_AT_RAIL: assert property (@(posedge clk) disable iff (rst)
    int_sat |-> (integ_q == RAIL_HI) || (integ_q == RAIL_LO)); // R7
  AST_OUT_SAT_RAIL: assert property (@(posedge clk) disable iff (rst)
    fire && !hold && !offset_en |=>
      !out_sat || (ctrl_out == RAIL_HI) || (ctrl_out == RAIL_LO)); // R8
endmodule

// File: tb/sim_pi_loop_filter.sv
module sim_pi_loop_filter;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W      = 4;
  localparam int OUT_W      = 6;
  localparam int GAIN_W     = 5;
  localparam int LIN_GMAX   = 3;
  localparam int INT_GMAX   = 4;
  localparam longint OMAX   = (longint'(1) <<< (OUT_W-1)) - 1;
  localparam longint OMIN   = -(longint'(1) <<< (OUT_W-1));

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              step_ce = 1'b0;
  logic              err_valid = 1'b0;
  logic              err_ready;
  logic [ERR_W-1:0]  err_data = '0;
  logic [GAIN_W-1:0] lin_gain = '0;
  logic [GAIN_W-1:0] int_gain = '0;
  logic              hold = 1'b0;
  logic              offset_en = 1'b0;
  logic [OUT_W-1:0]  offset_val = '0;
  logic [OUT_W-1:0]  ctrl_out;
  logic              in_sat, int_sat, out_sat;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  longint m_int, m_out;
  bit     m_isat, m_itsat, m_osat;

  always #(CLK_PERIOD/2) clk = ~clk;

  pi_loop_filter #(
    .ERR_W(ERR_W), .OUT_W(OUT_W), .GAIN_W(GAIN_W),
    .LIN_GMAX(LIN_GMAX), .INT_GMAX(INT_GMAX)
  ) u0 (
    .clk(clk), .rst(rst), .step_ce(step_ce), .err_valid(err_valid),
    .err_ready(err_ready), .err_data(err_data), .lin_gain(lin_gain),
    .int_gain(int_gain), .hold(hold), .offset_en(offset_en),
    .offset_val(offset_val), .ctrl_out(ctrl_out), .in_sat(in_sat),
    .int_sat(int_sat), .out_sat(out_sat)
  );

  function automatic longint clampv(longint v);
    if (v > OMAX) return OMAX;
    if (v < OMIN) return OMIN;
    return v;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(string out_req);
    chk(out_req, longint'($signed(ctrl_out)), m_out);
    chk("R6 in_sat", longint'(in_sat), longint'(m_isat));
    chk("R7 int_sat", longint'(int_sat), longint'(m_itsat));
    chk("R8 out_sat", longint'(out_sat), longint'(m_osat));
  endtask

  // R1: reset clears control word, integrator and flags
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; step_ce = 1'b0; err_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_int = 0; m_out = 0; m_isat = 0; m_itsat = 0; m_osat = 0;
    chk_all("R1 ctrl_out");
  endtask

  // one accepted transfer, checked against the arithmetic model
  task automatic do_fire(int e, int gl, int gi, bit h, bit oe, int ov);
    longint sl, si, lin, ig, isum, osum;
    string  req;
    int     gle, gie;
    bit     was_rail;
    @(negedge clk);
    err_data = ERR_W'(e); lin_gain = GAIN_W'(gl); int_gain = GAIN_W'(gi);
    hold = h; offset_en = oe; offset_val = OUT_W'(ov);
    err_valid = 1'b1; step_ce = 1'b1;
    @(posedge clk);
    #1;
    gle = (gl > LIN_GMAX) ? LIN_GMAX : gl;  // R3 gain ceiling
    gie = (gi > INT_GMAX) ? INT_GMAX : gi;  // R4 gain ceiling
    sl  = longint'(e) <<< gle;
    si  = longint'(e) <<< gie;
    lin = clampv(sl);
    ig  = clampv(si);
    was_rail = (m_int == OMAX) || (m_int == OMIN);
    isum = m_int + ig;
    m_int = clampv(isum);
    osum = lin + m_int;
    m_isat  = (lin != sl) || (ig != si);
    m_itsat = (m_int != isum);
    m_osat  = (clampv(osum) != osum);
    if (h)             req = "R9 hold";
    else if (oe)       req = "R10 offset";
    else if (was_rail) req = "R4 rail resume";
    else               req = "R5 R3 filter sum";
    if (!h) m_out = oe ? longint'(ov) : clampv(osum);
    chk_all(req);
  endtask

  // R2 R11: edge without a transfer leaves everything unchanged
  task automatic do_idle(bit v, bit ce, int e);
    @(negedge clk);
    err_valid = v; step_ce = ce; err_data = ERR_W'(e);
    lin_gain = GAIN_W'(1); int_gain = GAIN_W'(1);
    hold = 1'b0; offset_en = 1'b0;
    #1;
    chk("R2 ready", longint'(err_ready), longint'(ce));
    @(posedge clk);
    #1;
    chk_all("R2 no transfer");
    chk("R11 flags kept", longint'({in_sat, int_sat, out_sat}),
        longint'({m_isat, m_itsat, m_osat}));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_int = 0; m_out = 0; m_isat = 0; m_itsat = 0; m_osat = 0;
    @(posedge clk);
    @(posedge clk);
    do_reset();

    // near-exhaustive sweep: every error value, gains past each ceiling
    for (int gl = 0; gl <= LIN_GMAX + 1; gl++) begin
      for (int gi = 0; gi <= INT_GMAX + 1; gi++) begin
        do_reset();
        for (int e = -(1 << (ERR_W-1)); e < (1 << (ERR_W-1)); e++)
          do_fire(e, gl, gi, 1'b0, 1'b0, 0);
        // reverse sweep pulls the integrator off the opposite rail
        for (int e = (1 << (ERR_W-1)) - 1; e >= -(1 << (ERR_W-1)); e--)
          do_fire(e, gl, gi, 1'b0, 1'b0, 0);
      end
    end

    // R2: valid alone, enable alone, neither
    do_reset();
    do_fire(3, 1, 1, 1'b0, 1'b0, 0);
    do_idle(1'b1, 1'b0, 5);
    do_idle(1'b0, 1'b1, -4);
    do_idle(1'b0, 1'b0, 7);
    do_fire(-2, 2, 0, 1'b0, 1'b0, 0);
    do_idle(1'b1, 1'b0, -8);

    // R10: override walks every offset value
    do_reset();
    for (int ov = OMIN; ov <= OMAX; ov++)
      do_fire((ov % 3) - 1, 1, 0, 1'b0, 1'b1, int'(ov));

    // R9: hold freezes output while integrator keeps moving
    do_reset();
    do_fire(2, 1, 0, 1'b0, 1'b0, 0);
    for (int k = 0; k < 6; k++)
      do_fire(3, 2, 1, 1'b1, k[0], -20);
    do_fire(0, 0, 0, 1'b0, 1'b0, 0);   // release: integrator shows through
    for (int k = 0; k < 4; k++)
      do_fire(-7, 3, 4, 1'b1, 1'b0, 0);
    do_fire(1, 0, 0, 1'b0, 1'b0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule